// File: doc/BRIEF.md
# Receive Line Quiet-Time Detector

This block sits beside a serial receiver and decides when the incoming line has gone quiet. It counts bit-time ticks for as long as a chosen quiet condition holds, and once the count reaches a programmable limit it raises a sticky idle flag. Software uses the flag, or the gated interrupt derived from it, to learn that a burst of traffic has ended. It then clears the flag with a one-cycle write-one-to-clear strobe.

The quiet condition is one of two sources, picked by a select input. The first is the raw receive pin being high. The second is the receiver state machine reporting idle. A master enable gates both sources. The flag fires once per quiet period. If software clears it while the line is still quiet, it stays clear until the line has been busy and then quiet again.

The flag logic is a four-state machine (type `rxq_state_t`):
- `ST_ARMED`: flag low, waiting for the limit to be reached. It moves to `ST_HELD` on a hit.
- `ST_HELD`: flag high, the line still quiet.
  - A clear while still quiet moves it to `ST_SPENT`.
  - A clear in the same cycle as the line going busy moves it to `ST_ARMED`.
  - The line going busy with no clear moves it to `ST_LATCHED`.
- `ST_LATCHED`: flag high, the line has been busy since the hit. A new hit moves it to `ST_HELD`, and a hit takes priority over a clear in the same cycle. A clear alone moves it to `ST_ARMED`.
- `ST_SPENT`: flag low, the hit already consumed. The line going busy moves it to `ST_ARMED`.

Top module: `rx_quiet_watch`

## Requirements
- R1: While the quiet condition holds, the counter advances by one on each cycle with `bit_tick` high, and only on those cycles. `idle_flag` rises on the clock edge of the tick that brings the count to `quiet_limit`, and not earlier.
- R2: With `cond_sel`=0 the quiet condition is `rx_pin`=1 and `rx_sm_idle` is ignored. With `cond_sel`=1 the quiet condition is `rx_sm_idle`=1 and `rx_pin` is ignored.
- R3: Any cycle in which the quiet condition is false resets the count to zero.
- R4: With `det_en`=0 the condition is false, the count stays at zero and no flag is raised.
- R5: `idle_flag` (1 = idle, 0 = busy) is sticky. It stays high when the line goes busy, and a `flag_clr` pulse with no set event in that cycle drops it on the next edge.
- R6: A quiet period raises the flag at most once. After a clear during continued quiet, the flag stays low until the condition has dropped and the limit has been reached again.
- R7: When a set event and `flag_clr` fall in the same cycle, the flag is high afterwards.
- R8: A `quiet_limit` of 0 behaves as a limit of 1, so a single tick sets the flag.
- R9: `idle_irq` is high exactly when `idle_flag` is high and `irq_en` is 1.
- R10: After reset, `idle_flag` and `idle_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_pin | input | 1 | Receive line, already synchronous to clk |
| rx_sm_idle | input | 1 | Receiver state machine reports idle |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| det_en | input | 1 | Detection enable |
| cond_sel | input | 1 | 0: pin high is quiet, 1: receiver idle is quiet |
| quiet_limit | input | CW (8) | Quiet threshold in bit times, 0 treated as 1 |
| irq_en | input | 1 | Interrupt enable for the idle flag |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| idle_flag | output | 1 | Sticky idle flag |
| idle_irq | output | 1 | Flag gated by irq_en |

## Verification
The assertions rely on the set event needing a tick, an enabled detector and a true selected condition, all sampled in the same cycle. Inputs are taken as synchronous to `clk`, with `bit_tick` and `flag_clr` treated as arbitrary levels sampled at each edge. The bench drives every input at the falling edge and keeps `bit_tick` a single-cycle pulse with a quiet cycle after it. It changes configuration only while the line is busy, or at points where the expected count is known. This keeps every expected flag value a direct count of ticks since the condition last came true.

// File: rtl/rx_quiet_pkg.sv
package rx_quiet_pkg;

    // Flag machine: flag level and whether a new hit may set it.
    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,  // flag low, hit allowed
        ST_HELD    = 2'd1,  // flag high, quiet period still running
        ST_LATCHED = 2'd2,  // flag high, line went busy since the hit
        ST_SPENT   = 2'd3   // flag low, quiet period already reported
    } rxq_state_t;

    localparam int unsigned RXQ_LIMIT_W = 8;

endpackage

// File: rtl/rxq_cond_sel.sv
module rxq_cond_sel (
    input  logic rx_pin,
    input  logic rx_sm_idle,
    input  logic cond_sel,
    input  logic det_en,
    output logic quiet
);

    logic src;

    always_comb begin
        if (cond_sel) src = rx_sm_idle;
        else          src = rx_pin;
        quiet = det_en & src;
    end

endmodule

// File: rtl/rxq_quiet_cnt.sv
module rxq_quiet_cnt #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          quiet,
    input  logic          bit_tick,
    input  logic [CW-1:0] quiet_limit,
    output logic          hit
);

    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_eff;

    // A zero limit counts as one bit time.
    always_comb begin
        lim_eff = (quiet_limit == '0) ? ONE : quiet_limit;
        hit     = quiet & bit_tick & (cnt_q == lim_eff - ONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!quiet)
            cnt_q <= '0;
        else if (bit_tick && cnt_q < lim_eff)
            cnt_q <= cnt_q + ONE;
    end

endmodule

// File: rtl/rxq_flag_fsm.sv
module rxq_flag_fsm
    import rx_quiet_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic quiet,
    input  logic clr,
    output logic flag
);

    rxq_state_t st_q, st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_ARMED;
        else        st_q <= st_nxt;
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_ARMED: begin
                if (hit) st_nxt = ST_HELD;
            end
            ST_HELD: begin
                if (clr)         st_nxt = quiet ? ST_SPENT : ST_ARMED;
                else if (!quiet) st_nxt = ST_LATCHED;
            end
            ST_LATCHED: begin
                if (hit)      st_nxt = ST_HELD;   // set beats clear
                else if (clr) st_nxt = ST_ARMED;
            end
            ST_SPENT: begin
                if (!quiet) st_nxt = ST_ARMED;
            end
            default: st_nxt = ST_ARMED;
        endcase
    end

    always_comb begin
        flag = (st_q == ST_HELD) || (st_q == ST_LATCHED);
    end

endmodule

// File: rtl/rx_quiet_watch.sv
module rx_quiet_watch #(
    parameter int unsigned CW = rx_quiet_pkg::RXQ_LIMIT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_pin,
    input  logic          rx_sm_idle,
    input  logic          bit_tick,
    input  logic          det_en,
    input  logic          cond_sel,
    input  logic [CW-1:0] quiet_limit,
    input  logic          irq_en,
    input  logic          flag_clr,
    output logic          idle_flag,
    output logic          idle_irq
);

    logic quiet;
    logic hit;

    rxq_cond_sel u_cond (
        .rx_pin     (rx_pin),
        .rx_sm_idle (rx_sm_idle),
        .cond_sel   (cond_sel),
        .det_en     (det_en),
        .quiet      (quiet)
    );

    rxq_quiet_cnt #(.CW(CW)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .quiet       (quiet),
        .bit_tick    (bit_tick),
        .quiet_limit (quiet_limit),
        .hit         (hit)
    );

    rxq_flag_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .quiet (quiet),
        .clr   (flag_clr),
        .flag  (idle_flag)
    );

    assign idle_irq = idle_flag & irq_en;

endmodule

// File: rtl/rx_quiet_watch_chk.sv
module rx_quiet_watch_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_pin,
    input logic bit_tick,
    input logic det_en,
    input logic cond_sel,
    input logic irq_en,
    input logic flag_clr,
    input logic idle_flag,
    input logic idle_irq
);

    // R1
    tick_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_flag && !bit_tick) |=> !idle_flag);

    // R2
    pin_low_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_flag && !cond_sel && !rx_pin) |=> !idle_flag);

    // R4
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_flag && !det_en) |=> !idle_flag);

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_flag && !flag_clr) |=> idle_flag);

    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_flag && flag_clr && !bit_tick) |=> !idle_flag);

    // R9
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_irq |-> (irq_en && idle_flag));

endmodule

bind rx_quiet_watch rx_quiet_watch_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_pin    (rx_pin),
    .bit_tick  (bit_tick),
    .det_en    (det_en),
    .cond_sel  (cond_sel),
    .irq_en    (irq_en),
    .flag_clr  (flag_clr),
    .idle_flag (idle_flag),
    .idle_irq  (idle_irq)
);

// File: tb/rx_quiet_watch_test.sv
`timescale 1ns/1ps
module rx_quiet_watch_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_pin = 1'b0;
    logic       rx_sm_idle = 1'b0;
    logic       bit_tick = 1'b0;
    logic       det_en = 1'b0;
    logic       cond_sel = 1'b0;
    logic [7:0] quiet_limit = 8'd1;
    logic       irq_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       idle_flag;
    logic       idle_irq;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rx_quiet_watch uut (
        .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .rx_sm_idle(rx_sm_idle),
        .bit_tick(bit_tick), .det_en(det_en), .cond_sel(cond_sel),
        .quiet_limit(quiet_limit), .irq_en(irq_en), .flag_clr(flag_clr),
        .idle_flag(idle_flag), .idle_irq(idle_irq)
    );

    typedef struct packed {
        logic       sel;
        logic       rx;
        logic       sm;
        logic [7:0] lim;
        logic [8:0] ticks;
        logic       exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b0, 8'd3,   9'd2,   1'b0},  // R1 one short
        '{1'b0, 1'b1, 1'b0, 8'd3,   9'd3,   1'b1},  // R1 exact
        '{1'b0, 1'b0, 1'b1, 8'd2,   9'd5,   1'b0},  // R2 pin low, sm ignored
        '{1'b1, 1'b0, 1'b1, 8'd2,   9'd2,   1'b1},  // R2 sm idle, pin ignored
        '{1'b1, 1'b1, 1'b0, 8'd2,   9'd6,   1'b0},  // R2 sm busy, pin ignored
        '{1'b0, 1'b1, 1'b0, 8'd0,   9'd1,   1'b1},  // R8 zero as one
        '{1'b0, 1'b1, 1'b0, 8'd1,   9'd1,   1'b1},  // R8 one
        '{1'b0, 1'b1, 1'b0, 8'd255, 9'd254, 1'b0},  // R1 max short
        '{1'b0, 1'b1, 1'b0, 8'd255, 9'd255, 1'b1},  // R1 max exact
        '{1'b1, 1'b1, 1'b1, 8'd4,   9'd4,   1'b1}   // R2 both quiet
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1;
            step();
            bit_tick = 1'b0;
            step();
        end
    endtask

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // busy line for one cycle, then a clear: leaves the machine armed, flag low
    task automatic go_busy_clear();
        rx_pin = 1'b0;
        rx_sm_idle = 1'b0;
        step();
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
    endtask

    task automatic set_quiet();
        cond_sel = 1'b0;
        rx_pin = 1'b1;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(idle_flag, 1'b0, "R10 flag in reset");
        chk(idle_irq, 1'b0, "R10 irq in reset");
        rst_n = 1'b1;
        step();
        chk(idle_flag, 1'b0, "R10 flag after reset");
        chk(idle_irq, 1'b0, "R10 irq after reset");

        det_en = 1'b1;
        irq_en = 1'b1;

        for (int v = 0; v < NV; v++) begin
            go_busy_clear();
            cond_sel = VECS[v].sel;
            rx_pin = VECS[v].rx;
            rx_sm_idle = VECS[v].sm;
            quiet_limit = VECS[v].lim;
            step();
            tick(int'(VECS[v].ticks));
            chk(idle_flag, VECS[v].exp, $sformatf("R1/R2/R8 vector %0d flag", v));
            chk(idle_irq, VECS[v].exp, $sformatf("R9 vector %0d irq", v));
        end

        // R1: quiet held with no ticks does not count
        go_busy_clear();
        quiet_limit = 8'd1;
        set_quiet();
        repeat (20) step();
        chk(idle_flag, 1'b0, "R1 no ticks no flag");
        tick(1);
        chk(idle_flag, 1'b1, "R1 first tick sets");

        // R3: a busy cycle restarts the count
        go_busy_clear();
        quiet_limit = 8'd3;
        set_quiet();
        tick(2);
        rx_pin = 1'b0;
        step();
        rx_pin = 1'b1;
        step();
        tick(2);
        chk(idle_flag, 1'b0, "R3 count restarted");
        tick(1);
        chk(idle_flag, 1'b1, "R3 limit after restart");

        // R5: sticky through busy, clear drops
        rx_pin = 1'b0;
        step();
        chk(idle_flag, 1'b1, "R5 sticky while busy");
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        chk(idle_flag, 1'b0, "R5 cleared");

        // R4: disabled detector raises nothing and holds count at zero
        quiet_limit = 8'd2;
        det_en = 1'b0;
        set_quiet();
        tick(5);
        chk(idle_flag, 1'b0, "R4 disabled no flag");
        det_en = 1'b1;
        step();
        tick(1);
        chk(idle_flag, 1'b0, "R4 count from zero after enable");
        tick(1);
        chk(idle_flag, 1'b1, "R4 flag after enable");

        // R6: clear during continued quiet does not re-fire
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        chk(idle_flag, 1'b0, "R6 cleared while quiet");
        tick(6);
        chk(idle_flag, 1'b0, "R6 no re-fire");
        rx_pin = 1'b0;
        step();
        rx_pin = 1'b1;
        step();
        tick(2);
        chk(idle_flag, 1'b1, "R6 re-armed after busy");

        // R7: set and clear in the same cycle, set wins
        rx_pin = 1'b0;
        step();
        rx_pin = 1'b1;
        step();
        tick(1);
        bit_tick = 1'b1;
        flag_clr = 1'b1;
        step();
        bit_tick = 1'b0;
        flag_clr = 1'b0;
        chk(idle_flag, 1'b1, "R7 set beats clear");
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        chk(idle_flag, 1'b0, "R7 later clear works");

        // R9: interrupt gating
        rx_pin = 1'b0;
        step();
        rx_pin = 1'b1;
        step();
        irq_en = 1'b0;
        tick(2);
        chk(idle_flag, 1'b1, "R9 flag set");
        chk(idle_irq, 1'b0, "R9 irq masked");
        irq_en = 1'b1;
        step();
        chk(idle_irq, 1'b1, "R9 irq enabled");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule